// File: doc/BRIEF.md
# Latency-configurable memory port with handshake

This block wraps one port of a synchronous single-cycle RAM and lets the integrator trade read latency for timing slack. An optional capture stage can sit in front of the storage for address, write data and write strobe, and an optional register stage can sit behind it. The total read latency is therefore one, two or three active clock edges. A parameter picks what the data output shows during a write: the data being written, the data being overwritten, or the last read result.

Alongside the data path the block produces a flow-control trio. The caller marks a request with a new-request strobe. The block shows that it can accept requests with an accept flag, and raises a data-valid flag in the cycle when the result of the marked request sits on the data output. The valid flag is the request strobe carried through a shift line whose length equals the configured latency. A single port enable freezes every stage of both the data path and that shift line. An initialise input forces the last output stage to a parameter value.

Top module: `mem_port_pipe`

## Requirements
- R1: With no capture stage and no output stage, the word at the address presented in a cycle appears on `dout` right after that cycle's rising edge.
- R2: The capture stage adds one cycle of read latency and the output stage adds one more, so the latency is 1 + IN_REG + OUT_REG cycles.
- R3: With WMODE = 0 (write-through), the written word reaches `dout` after 1, 2, 2 or 3 rising edges with neither stage, capture stage only, output stage only, or both.
- R4: With WMODE = 1 (old-data), a write shows the word previously held at the written address on `dout`.
- R5: With WMODE = 2 (hold), a write leaves `dout` unchanged and still showing the last read result.
- R6: `rdy` equals `req` delayed by exactly the configured latency in enabled cycles; `req` has no effect on memory contents or on `dout`.
- R7: `acc` is high exactly while `en` is high; a `req` in a cycle with `en` low never produces an `rdy` pulse.
- R8: While `en` is low every stage holds: `dout` and `rdy` keep their values and a write presented in that cycle is not stored.
- R9: `init` high in an enabled cycle loads INIT_VAL into the last output stage at that edge; the memory write of that cycle still happens and `rdy` follows R6 unchanged.
- R10: After reset `dout` equals INIT_VAL and `rdy` is low; memory contents are not reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all operations on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| en | input | 1 | Port enable, active high; low freezes all stages |
| we | input | 1 | Write strobe, active high |
| init | input | 1 | Load INIT_VAL into the last output stage, active high |
| req | input | 1 | Marks a new valid address this cycle |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data from the last stage |
| acc | output | 1 | Port can take a request (follows `en`) |
| rdy | output | 1 | `dout` holds the result of a marked request |

## Verification
The hardest situation to reach from the ports is an `rdy` pulse that is still inside the shift line while the port is disabled, or an initialise landing between a request and its result. The stimulus holds four instances with every stage combination side by side on the same inputs, streams reads with random gaps in `req`, then drops `en` for several cycles with both `req` and a write pending, and later fires `init` in a write cycle with a request in flight. The expected output for each latency is taken from a per-cycle history of the enabled cycles, so each gap and freeze shows up as an exact cycle offset.

// File: rtl/mpp_pkg.sv
package mpp_pkg;

    typedef enum logic [1:0] {
        WM_WRITE_THRU = 2'd0,
        WM_OLD_DATA   = 2'd1,
        WM_HOLD       = 2'd2
    } wmode_e;

    function automatic int unsigned pipe_latency(bit in_reg, bit out_reg);
        return 1 + int'(in_reg) + int'(out_reg);
    endfunction

endpackage

// File: rtl/mpp_in_stage.sv
module mpp_in_stage #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter bit EN_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] din_o
);

    generate
        if (EN_REG) begin : g_reg
            typedef struct packed {
                logic              we;
                logic [ADDR_W-1:0] addr;
                logic [DATA_W-1:0] din;
            } cap_t;

            cap_t cap_d, cap_q;

            always_comb begin
                cap_d = cap_q;
                if (en) begin
                    cap_d.we   = we_i;
                    cap_d.addr = addr_i;
                    cap_d.din  = din_i;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cap_q <= '0;
                else        cap_q <= cap_d;
            end

            assign we_o   = cap_q.we;
            assign addr_o = cap_q.addr;
            assign din_o  = cap_q.din;
        end else begin : g_pass
            logic unused_pass;
            assign unused_pass = ^{clk, rst_n, en};
            assign we_o   = we_i;
            assign addr_o = addr_i;
            assign din_o  = din_i;
        end
    endgenerate

endmodule

// File: rtl/mpp_ram.sv
module mpp_ram
    import mpp_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 4,
    parameter wmode_e            WMODE     = WM_WRITE_THRU,
    parameter bit                TAKE_INIT = 1'b0,
    parameter logic [DATA_W-1:0] INIT_VAL  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              init,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    // Storage array: written only in enabled cycles, never reset.
    always_ff @(posedge clk) begin
        if (en && we) mem[addr] <= din;
    end

    // Read register: the write mode decides what a write cycle shows.
    always_comb begin
        rd_d = rd_q;
        if (en) begin
            if (!we) begin
                rd_d = mem[addr];
            end else begin
                case (WMODE)
                    WM_WRITE_THRU: rd_d = din;
                    WM_OLD_DATA:   rd_d = mem[addr];
                    default:       rd_d = rd_q;
                endcase
            end
            if (TAKE_INIT && init) rd_d = INIT_VAL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= INIT_VAL;
        else        rd_q <= rd_d;
    end

    assign rd_o = rd_q;

endmodule

// File: rtl/mpp_out_stage.sv
module mpp_out_stage #(
    parameter int                DATA_W   = 8,
    parameter bit                EN_REG   = 1'b1,
    parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              init,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);

    generate
        if (EN_REG) begin : g_reg
            logic [DATA_W-1:0] out_d, out_q;

            always_comb begin
                out_d = out_q;
                if (en) out_d = init ? INIT_VAL : d_i;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) out_q <= INIT_VAL;
                else        out_q <= out_d;
            end

            assign q_o = out_q;
        end else begin : g_pass
            logic unused_pass;
            assign unused_pass = ^{clk, rst_n, en, init};
            assign q_o = d_i;
        end
    endgenerate

endmodule

// File: rtl/mpp_ready_line.sv
module mpp_ready_line #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic req,
    output logic rdy
);

    logic [LAT-1:0] line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (en) begin
            line_d[0] = req;
            for (int k = 1; k < LAT; k++) line_d[k] = line_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign rdy = line_q[LAT-1];

endmodule

// File: rtl/mem_port_pipe.sv
module mem_port_pipe
    import mpp_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                ADDR_W   = 4,
    parameter bit                IN_REG   = 1'b1,
    parameter bit                OUT_REG  = 1'b1,
    parameter wmode_e            WMODE    = WM_WRITE_THRU,
    parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic              init,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              acc,
    output logic              rdy
);

    localparam int LAT = pipe_latency(IN_REG, OUT_REG);
    // Initialise lands in the storage read register only when it is the last stage.
    localparam bit INIT_IN_RAM = !OUT_REG;

    logic              s_we;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_din;
    logic [DATA_W-1:0] ram_rd;

    assign acc = en;

    mpp_in_stage #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .EN_REG (IN_REG)
    ) u_in (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .we_i   (we),
        .addr_i (addr),
        .din_i  (din),
        .we_o   (s_we),
        .addr_o (s_addr),
        .din_o  (s_din)
    );

    mpp_ram #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .WMODE     (WMODE),
        .TAKE_INIT (INIT_IN_RAM),
        .INIT_VAL  (INIT_VAL)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .init  (init),
        .we    (s_we),
        .addr  (s_addr),
        .din   (s_din),
        .rd_o  (ram_rd)
    );

    mpp_out_stage #(
        .DATA_W   (DATA_W),
        .EN_REG   (OUT_REG),
        .INIT_VAL (INIT_VAL)
    ) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .init  (init),
        .d_i   (ram_rd),
        .q_o   (dout)
    );

    mpp_ready_line #(
        .LAT (LAT)
    ) u_rdy (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .req   (req & acc),
        .rdy   (rdy)
    );

endmodule

// File: rtl/mpp_checker.sv
module mpp_checker
    import mpp_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                LAT      = 3,
    parameter bit                IN_REG   = 1'b1,
    parameter bit                OUT_REG  = 1'b1,
    parameter wmode_e            WMODE    = WM_WRITE_THRU,
    parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              we,
    input logic              init,
    input logic              req,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              rdy
);

    logic unused_chk;
    assign unused_chk = ^{we, din};

    // Number of request tokens travelling toward rdy.
    logic [7:0] tokens_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  tokens_q <= '0;
        else if (en) tokens_q <= tokens_q + 8'(req) - 8'(rdy);
    end

    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(dout) && $stable(rdy)));

    p_rdy_has_token_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> (tokens_q != 8'd0));

    p_token_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tokens_q) <= LAT);

    p_init_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && init) |=> (dout == INIT_VAL));

    generate
        if (!IN_REG && !OUT_REG && WMODE == WM_WRITE_THRU) begin : g_wt
            p_write_thru_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (en && we && !init) |=> (dout == $past(din)));
        end
        if (!IN_REG && !OUT_REG && WMODE == WM_HOLD) begin : g_hold
            p_hold_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (en && we && !init) |=> $stable(dout));
        end
    endgenerate

endmodule

bind mem_port_pipe mpp_checker #(
    .DATA_W   (DATA_W),
    .LAT      (LAT),
    .IN_REG   (IN_REG),
    .OUT_REG  (OUT_REG),
    .WMODE    (WMODE),
    .INIT_VAL (INIT_VAL)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .we    (we),
    .init  (init),
    .req   (req),
    .din   (din),
    .dout  (dout),
    .rdy   (rdy)
);

// File: tb/mem_port_pipe_tb.sv
module mem_port_pipe_tb;
    import mpp_pkg::*;

    localparam int         CLK_PERIOD = 10;
    localparam int         DW         = 8;
    localparam int         AW         = 4;
    localparam logic [7:0] INIT       = 8'hA5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0, we = 1'b0, init = 1'b0, req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;

    logic [DW-1:0] dout_g [4];
    logic          rdy_g  [4];
    logic          acc_g  [4];
    logic [DW-1:0] dout_rf, dout_nc;
    logic          rdy_rf, rdy_nc, acc_rf, acc_nc;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Index g: bit 0 = capture stage, bit 1 = output stage.
    for (genvar g = 0; g < 4; g++) begin : gen_cfg
        mem_port_pipe #(
            .DATA_W (DW), .ADDR_W (AW),
            .IN_REG (bit'(g % 2)), .OUT_REG (bit'(g / 2)),
            .WMODE (WM_WRITE_THRU), .INIT_VAL (INIT)
        ) u_dut (
            .clk (clk), .rst_n (rst_n), .en (en), .we (we), .init (init),
            .req (req), .addr (addr), .din (din),
            .dout (dout_g[g]), .acc (acc_g[g]), .rdy (rdy_g[g])
        );
    end

    mem_port_pipe #(
        .DATA_W (DW), .ADDR_W (AW), .IN_REG (1'b0), .OUT_REG (1'b0),
        .WMODE (WM_OLD_DATA), .INIT_VAL (INIT)
    ) u_rf (
        .clk (clk), .rst_n (rst_n), .en (en), .we (we), .init (init),
        .req (req), .addr (addr), .din (din),
        .dout (dout_rf), .acc (acc_rf), .rdy (rdy_rf)
    );

    mem_port_pipe #(
        .DATA_W (DW), .ADDR_W (AW), .IN_REG (1'b0), .OUT_REG (1'b0),
        .WMODE (WM_HOLD), .INIT_VAL (INIT)
    ) u_nc (
        .clk (clk), .rst_n (rst_n), .en (en), .we (we), .init (init),
        .req (req), .addr (addr), .din (din),
        .dout (dout_nc), .acc (acc_nc), .rdy (rdy_nc)
    );

    // Reference state built from the requirements.
    logic [DW-1:0] ref_mem [16];
    logic [DW-1:0] ex_h [1024];
    bit            req_h [1024];
    int            hi = 0;
    logic [DW-1:0] d_exp [4];
    bit            d_ok  [4];
    bit            r_exp [4];
    logic [DW-1:0] rf_exp = INIT, nc_exp = INIT, nc_hold = INIT;
    bit            chk_rf = 1'b0;
    int            n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic step(input bit e, input bit w, input bit r, input bit s,
                        input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input string tag);
        logic [DW-1:0] wt;
        int            lat, j;
        string         dtag;
        en = e; we = w; req = r; init = s; addr = a; din = d;
        if (e) begin
            wt      = w ? d : ref_mem[a];
            rf_exp  = s ? INIT : ref_mem[a];
            nc_exp  = s ? INIT : (w ? nc_hold : ref_mem[a]);
            nc_hold = nc_exp;
            if (w) ref_mem[a] = d;
            ex_h[hi]  = wt;
            req_h[hi] = r;
            hi++;
            for (int g = 0; g < 4; g++) begin
                lat = 1 + (g % 2) + (g / 2);
                j   = hi - lat;
                if (s)           begin d_exp[g] = INIT;    d_ok[g] = 1'b1; end
                else if (j >= 0) begin d_exp[g] = ex_h[j]; d_ok[g] = 1'b1; end
                else             d_ok[g] = 1'b0;
                r_exp[g] = (j >= 0) ? req_h[j] : 1'b0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int g = 0; g < 4; g++) begin
            dtag = (tag == "RD") ? ((g == 0) ? "R1" : "R2") : tag;
            if (d_ok[g]) check(dout_g[g] === d_exp[g], dtag, $sformatf("dout cfg%0d", g),
                               32'(dout_g[g]), 32'(d_exp[g]));
            check(rdy_g[g] === r_exp[g], "R6", $sformatf("rdy cfg%0d", g),
                  32'(rdy_g[g]), 32'(r_exp[g]));
        end
        if (chk_rf) check(dout_rf === rf_exp, "R4", "dout old-data", 32'(dout_rf), 32'(rf_exp));
        check(dout_nc === nc_exp, "R5", "dout hold", 32'(dout_nc), 32'(nc_exp));
        check(acc_g[3] === e, "R7", "acc", 32'(acc_g[3]), 32'(e));
    endtask

    task automatic t_reset();
        for (int g = 0; g < 4; g++) begin
            check(dout_g[g] === INIT, "R10", $sformatf("reset dout cfg%0d", g), 32'(dout_g[g]), 32'(INIT));
            check(rdy_g[g] === 1'b0, "R10", $sformatf("reset rdy cfg%0d", g), 32'(rdy_g[g]), 32'd0);
            d_exp[g] = INIT; d_ok[g] = 1'b1; r_exp[g] = 1'b0;
        end
        check(dout_nc === INIT, "R10", "reset dout hold", 32'(dout_nc), 32'(INIT));
    endtask

    task automatic t_fill();
        for (int i = 0; i < 16; i++) step(1, 1, 0, 0, 4'(i), 8'(8'h10 + i * 7), "R3");
        chk_rf = 1'b1;
    endtask

    task automatic t_stream();
        for (int i = 0; i < 48; i++)
            step(1, 0, ($urandom_range(0, 2) == 0) ? 1'b0 : 1'b1, 0,
                 4'($urandom_range(0, 15)), 8'($urandom_range(0, 255)), "RD");
    endtask

    task automatic t_modes();
        step(1, 0, 1, 0, 4'd3, 8'h00, "R4");
        step(1, 1, 1, 0, 4'd3, 8'h5A, "R3");
        step(1, 1, 0, 0, 4'd5, 8'hC3, "R3");
        step(1, 0, 1, 0, 4'd3, 8'h00, "R4");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 4'd5, 8'h00, "RD");
    endtask

    task automatic t_freeze();
        step(1, 0, 1, 0, 4'd7, 8'h00, "RD");
        step(1, 0, 0, 0, 4'd8, 8'h00, "RD");
        for (int i = 0; i < 3; i++) step(0, 1, 1, 0, 4'd7, 8'hEE, "R8");
        for (int i = 0; i < 4; i++) step(1, 0, i == 0, 0, 4'd7, 8'h00, "R8");
    endtask

    task automatic t_init();
        step(1, 0, 1, 0, 4'd2, 8'h00, "RD");
        step(1, 1, 1, 1, 4'd9, 8'h3C, "R9");
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 4'd9, 8'h00, "R9");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 4'd0, 8'h00, "RD");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_stream();
        t_modes();
        t_freeze();
        t_init();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule